// File: doc/BRIEF.md
# Carrier-Compare PWM Generator with Dead-Time Insertion

This block produces the four gate signals for one half-bridge pair (leg A) and a second pair (leg B), which together drive a half-bridge or full-bridge power stage. A reference value is compared against an internal carrier counter. The carrier is either a rising ramp or a symmetric up/down ramp. Its period is one of five switching frequencies derived from the system clock. Leg B is either the inverse of leg A (bipolar switching) or an independent comparison against the negated reference (unipolar switching).

Every turn-on edge of every gate is delayed by a dead-time count, which is a fixed fraction of the PWM period taken from a five-entry selection. With this delay the two switches of a leg are never on at the same moment. A zero selection passes edges straight through, for use when the gate driver already adds its own dead time. The reference and all configuration inputs are sampled once per carrier period, at its start, so a change made mid-period never produces a runt pulse.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: While reset is asserted, and in the cycle that reset is released, all four gate outputs are low.
- R2: The carrier period in clocks is CLK_HZ divided by the selected frequency, where freq_sel codes 0,1,2,3,4 give 100, 50, 25, 12 and 6 kHz and codes 5 to 7 behave as code 4. Integer division is used.
- R3: With carrier_tri=0, the carrier counts 0 up to P-1 and wraps. The raw leg A state is high while the carrier is below floor(u*P / 2^REF_W), where u is the REF_W-bit reference code.
- R4: With carrier_tri=1, the carrier counts 0 up to H-1, holds H-1 for one more cycle, then counts back down to 0, so one period lasts 2H clocks with H=floor(P/2). The threshold then uses H in place of P.
- R5: With ref_signed=0 the code u equals ref_in. With ref_signed=1, ref_in is two's complement and u is ref_in with its most significant bit inverted.
- R6: With unipolar=0, the raw leg B state is always the inverse of the raw leg A state.
- R7: With unipolar=1, the raw leg B state uses the same comparison with the code 2^REF_W-1-u, which is the bitwise complement of u.
- R8: The dead-time count is floor(P*k/10000), where dt_sel codes 0,1,2,3,4 give k=0,75,150,230,320 and codes 5 to 7 behave as code 4. Whenever a leg's raw state changes, both outputs of that leg stay low for that many cycles before the new side turns on.
- R9: gate_ah and gate_al are never high together, and neither are gate_bh and gate_bl.
- R10: The reference and configuration are captured only in the last cycle of a carrier period (and once just after reset). Changes at any other time have no effect until the next period.
- R11: A code u of 0 keeps the leg's high side off for the whole period. A code u of 2^REF_W-1 keeps it on for the whole period, with no edges inside the period.
- R12: The high-side output of a leg is driven by its raw state delayed by one clock. gate_ah and gate_bh follow the raw high state, and gate_al and gate_bl follow its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | REF_W | Duty reference |
| ref_signed | input | 1 | 1: reference is two's complement, 0: unsigned |
| freq_sel | input | 3 | Switching frequency select |
| carrier_tri | input | 1 | 1: up/down carrier, 0: ramp carrier |
| unipolar | input | 1 | 1: leg B compares negated reference, 0: leg B is inverse of leg A |
| dt_sel | input | 3 | Dead-time fraction select |
| gate_ah | output | 1 | Leg A high-side gate |
| gate_al | output | 1 | Leg A low-side gate |
| gate_bh | output | 1 | Leg B high-side gate |
| gate_bl | output | 1 | Leg B low-side gate |

## Verification
The assertions assume that CLK_HZ is large enough for every period to exceed two clocks and for the up/down half-period to be at least one. They also assume that the configuration inputs are stable within the clock in which they are sampled. The stimulus uses a reduced clock rate, which gives periods of 100 to 1666 clocks. It changes inputs only on the falling clock edge, including deliberate changes in the middle of a period. A behavioural model in the bench tracks the carrier, the captured settings and the dead-time delay with plain integers, and every output is compared against it on every cycle.

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen #(
  parameter int CLK_HZ = 50_000_000,
  parameter int REF_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_in,
  input  logic             ref_signed,
  input  logic [2:0]       freq_sel,
  input  logic             carrier_tri,
  input  logic             unipolar,
  input  logic [2:0]       dt_sel,
  output logic             gate_ah,
  output logic             gate_al,
  output logic             gate_bh,
  output logic             gate_bl
);

  localparam int NSEL  = 5;
  localparam int CNT_W = $clog2(CLK_HZ / 6000 + 2);
  localparam int PRD_W = REF_W + CNT_W;

  function automatic int per_of(input int k);
    case (k)
      0:       return CLK_HZ / 100000;
      1:       return CLK_HZ / 50000;
      2:       return CLK_HZ / 25000;
      3:       return CLK_HZ / 12000;
      default: return CLK_HZ / 6000;
    endcase
  endfunction

  function automatic int bp_of(input int k);
    case (k)
      0:       return 0;
      1:       return 75;
      2:       return 150;
      3:       return 230;
      default: return 320;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] thr(input logic [REF_W-1:0] u, input logic [CNT_W-1:0] s);
    logic [PRD_W-1:0] prod;
    prod = {{CNT_W{1'b0}}, u} * {{REF_W{1'b0}}, s};
    if (&u) return s;
    return prod[PRD_W-1:REF_W];
  endfunction

  logic [CNT_W-1:0] per_lut [NSEL];
  logic [CNT_W-1:0] dt_lut  [NSEL*NSEL];

  for (genvar f = 0; f < NSEL; f++) begin : g_per
    assign per_lut[f] = CNT_W'(per_of(f));
    for (genvar d = 0; d < NSEL; d++) begin : g_dt
      assign dt_lut[f*NSEL+d] = CNT_W'(per_of(f) * bp_of(d) / 10000);
    end
  end

  logic [2:0]       fsel, dsel;
  logic [4:0]       dt_idx;
  logic [CNT_W-1:0] per_new, span_new;
  logic [REF_W-1:0] u_a, u_b;

  assign fsel     = (freq_sel > 3'd4) ? 3'd4 : freq_sel;
  assign dsel     = (dt_sel > 3'd4) ? 3'd4 : dt_sel;
  assign dt_idx   = 5'(fsel) * 5'd5 + 5'(dsel);
  assign per_new  = per_lut[fsel];
  assign span_new = carrier_tri ? (per_new >> 1) : per_new;
  assign u_a      = ref_signed ? {~ref_in[REF_W-1], ref_in[REF_W-2:0]} : ref_in;
  assign u_b      = ~u_a;

  logic             run_q, down_q, tri_q, uni_q;
  logic [CNT_W-1:0] cnt_q, span_q, tha_q, thb_q, dt_q;
  logic             at_end, start;

  assign at_end = tri_q ? (down_q && cnt_q == '0) : (cnt_q == span_q - CNT_W'(1));
  assign start  = !run_q || at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      down_q <= 1'b0;
      tri_q  <= 1'b0;
      uni_q  <= 1'b0;
      cnt_q  <= '0;
      span_q <= '0;
      tha_q  <= '0;
      thb_q  <= '0;
      dt_q   <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      down_q <= 1'b0;
      cnt_q  <= '0;
      tri_q  <= carrier_tri;
      uni_q  <= unipolar;
      span_q <= span_new;
      tha_q  <= thr(u_a, span_new);
      thb_q  <= thr(u_b, span_new);
      dt_q   <= dt_lut[dt_idx];
    end else if (tri_q && !down_q) begin
      if (cnt_q == span_q - CNT_W'(1)) down_q <= 1'b1;
      else                             cnt_q  <= cnt_q + CNT_W'(1);
    end else if (tri_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  logic [1:0]       raw, leg_q, hi, lo;
  logic [CNT_W-1:0] dcnt_q [2];

  assign raw[0] = cnt_q < tha_q;
  assign raw[1] = uni_q ? (cnt_q < thb_q) : !raw[0];

  for (genvar g = 0; g < 2; g++) begin : g_leg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        leg_q[g]  <= 1'b0;
        dcnt_q[g] <= '0;
      end else begin
        leg_q[g] <= raw[g];
        if (raw[g] != leg_q[g])    dcnt_q[g] <= dt_q;
        else if (dcnt_q[g] != '0)  dcnt_q[g] <= dcnt_q[g] - CNT_W'(1);
      end
    end
    assign hi[g] = run_q && leg_q[g]  && dcnt_q[g] == '0;
    assign lo[g] = run_q && !leg_q[g] && dcnt_q[g] == '0;

    p_leg_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(hi[g] && lo[g]));
    p_dead_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_q) && leg_q[g] != $past(leg_q[g]) && $past(dt_q) != '0) |-> (!hi[g] && !lo[g]));
  end

  assign gate_ah = hi[0];
  assign gate_al = lo[0];
  assign gate_bh = hi[1];
  assign gate_bl = lo[1];

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n) run_q |-> cnt_q < span_q);
  p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_end) |=> ($stable(tha_q) && $stable(thb_q) && $stable(span_q) && $stable(dt_q)));
  p_bipolar_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !$past(uni_q)) |-> (leg_q[1] != leg_q[0]));
  p_th_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tha_q <= span_q && thb_q <= span_q));

endmodule

// File: tb/pwm_deadtime_gen_tb_top.sv
module pwm_deadtime_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int REF_W      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REF_W-1:0] ref_in = '0;
  logic ref_signed = 1'b0, carrier_tri = 1'b0, unipolar = 1'b0;
  logic [2:0] freq_sel = 3'd1, dt_sel = 3'd0;
  logic gate_ah, gate_al, gate_bh, gate_bl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_deadtime_gen #(.CLK_HZ(CLK_HZ), .REF_W(REF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_signed(ref_signed),
    .freq_sel(freq_sel), .carrier_tri(carrier_tri), .unipolar(unipolar),
    .dt_sel(dt_sel), .gate_ah(gate_ah), .gate_al(gate_al),
    .gate_bh(gate_bh), .gate_bl(gate_bl));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int period_of(input int fs);
    int freqs [5] = '{100000, 50000, 25000, 12000, 6000};
    return CLK_HZ / freqs[(fs > 4) ? 4 : fs];
  endfunction

  function automatic int frac_of(input int ds);
    int k [5] = '{0, 75, 150, 230, 320};
    return k[(ds > 4) ? 4 : ds];
  endfunction

  function automatic int thresh(input longint u, input longint span);
    if (u == (1 << REF_W) - 1) return int'(span);
    return int'((u * span) >>> REF_W);
  endfunction

  // behavioural reference model
  int m_run, m_cnt, m_down, m_tri, m_uni, m_span, m_tha, m_thb, m_dt;
  int m_leg [2];
  int m_dc  [2];

  always @(posedge clk) begin
    int r [2];
    int endc, p, ua;
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_down = 0; m_tri = 0; m_uni = 0;
      m_span = 0; m_tha = 0; m_thb = 0; m_dt = 0;
      for (int g = 0; g < 2; g++) begin m_leg[g] = 0; m_dc[g] = 0; end
    end else begin
      r[0] = (m_cnt < m_tha) ? 1 : 0;
      r[1] = m_uni ? ((m_cnt < m_thb) ? 1 : 0) : 1 - r[0];
      for (int g = 0; g < 2; g++) begin
        if (r[g] != m_leg[g]) begin m_leg[g] = r[g]; m_dc[g] = m_dt; end
        else if (m_dc[g] > 0) m_dc[g]--;
      end
      endc = m_tri ? (m_down && m_cnt == 0) : (m_cnt == m_span - 1);
      if (!m_run || endc) begin
        p = period_of(int'(freq_sel));
        m_tri = int'(carrier_tri); m_uni = int'(unipolar);
        m_span = m_tri ? p / 2 : p;
        ua = ref_signed ? (int'(ref_in) ^ (1 << (REF_W-1))) : int'(ref_in);
        m_tha = thresh(ua, m_span);
        m_thb = thresh(((1 << REF_W) - 1) - ua, m_span);
        m_dt = p * frac_of(int'(dt_sel)) / 10000;
        m_cnt = 0; m_down = 0; m_run = 1;
      end else if (m_tri && !m_down) begin
        if (m_cnt == m_span - 1) m_down = 1; else m_cnt++;
      end else if (m_tri) m_cnt--;
      else m_cnt++;
    end
  end

  // per-cycle comparison (R12 and the phase requirement)
  always @(negedge clk) begin
    int exp_v, act_v;
    if (rst_n && !done) begin
      exp_v = {m_run && m_leg[0] && m_dc[0] == 0, m_run && !m_leg[0] && m_dc[0] == 0,
               m_run && m_leg[1] && m_dc[1] == 0, m_run && !m_leg[1] && m_dc[1] == 0};
      act_v = {gate_ah, gate_al, gate_bh, gate_bl};
      check(act_v == exp_v, {cur_req, "/R12 gates"}, act_v, exp_v);
      check(!(gate_ah && gate_al) && !(gate_bh && gate_bl), "R9 overlap", act_v, 0);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_gap(output int gap);
    logic prev;
    do begin prev = gate_ah; @(negedge clk); end while (!(gate_ah && !prev));
    gap = 0;
    do begin prev = gate_ah; @(negedge clk); gap++; end while (!(gate_ah && !prev));
  endtask

  task automatic count_edges(input int n, output int e);
    logic prev;
    e = 0;
    for (int i = 0; i < n; i++) begin
      prev = gate_ah; @(negedge clk);
      if (gate_ah != prev) e++;
    end
  endtask

  task automatic count_dead(input int n, output int d);
    d = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!gate_ah && !gate_al) d++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int v;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check({gate_ah, gate_al, gate_bh, gate_bl} == 4'b0, "R1 reset", {gate_ah, gate_al, gate_bh, gate_bl}, 0);
    end
    rst_n = 1'b1;
    #1;
    check({gate_ah, gate_al, gate_bh, gate_bl} == 4'b0, "R1 release", {gate_ah, gate_al, gate_bh, gate_bl}, 0);

    // R3: ramp carrier, unsigned, no dead time
    cur_req = "R3"; ref_in = 16'h4000;
    cycles(600);
    rise_gap(v); check(v == 200, "R2 period f=50k", v, 200);

    // R8: dead time 1.5 % of 200 = 3 cycles, 2 transitions per period
    cur_req = "R8"; dt_sel = 3'd2;
    cycles(400);
    count_dead(400, v); check(v == 12, "R8 dead cycles", v, 12);

    // R4: up/down carrier, period 2*100
    cur_req = "R4"; carrier_tri = 1'b1; dt_sel = 3'd1;
    cycles(400);
    rise_gap(v); check(v == 200, "R4 tri period", v, 200);

    // R5: signed reference
    cur_req = "R5"; ref_signed = 1'b1; ref_in = 16'hE000;
    cycles(600);

    // R7: unipolar with up/down carrier, dt 4 cycles
    cur_req = "R7"; unipolar = 1'b1; dt_sel = 3'd3;
    cycles(600);

    // R6: bipolar ramp
    cur_req = "R6"; unipolar = 1'b0; carrier_tri = 1'b0; dt_sel = 3'd2; ref_signed = 1'b0; ref_in = 16'h9000;
    cycles(600);

    // R11: clamps
    cur_req = "R11"; dt_sel = 3'd0; ref_in = 16'hFFFF;
    cycles(400);
    count_edges(400, v); check(v == 0, "R11 full edges", v, 0);
    check(gate_ah == 1'b1, "R11 full level", gate_ah, 1);
    ref_in = 16'h0000;
    cycles(400);
    count_edges(400, v); check(v == 0, "R11 zero edges", v, 0);
    check(gate_ah == 1'b0 && gate_al == 1'b1, "R11 zero level", {gate_ah, gate_al}, 1);

    // R10: mid-period change takes effect next period
    cur_req = "R10"; ref_in = 16'h8000;
    cycles(400);
    rise_gap(v);
    cycles(10);
    ref_in = 16'h2000;
    begin
      int hc = 11;
      while (gate_ah) begin @(negedge clk); if (gate_ah) hc++; end
      check(hc == 100, "R10 old duty kept", hc, 100);
    end
    rise_gap(v); check(v == 200, "R10 period", v, 200);
    begin
      int hc = 1;
      @(negedge clk);
      while (gate_ah) begin hc++; @(negedge clk); end
      check(hc == 25, "R10 new duty", hc, 25);
    end

    // R2: frequency codes
    cur_req = "R2"; ref_in = 16'h8000; freq_sel = 3'd0;
    cycles(300);
    rise_gap(v); check(v == 100, "R2 period f=100k", v, 100);
    freq_sel = 3'd6;
    cycles(200);
    rise_gap(v); check(v == 1666, "R2 period code 6", v, 1666);

    finish_run();
  end
endmodule